// File: doc/BRIEF.md
# Four-Pin GPIO with Change-Triggered Host Report

This block is a small general-purpose I/O peripheral that serves four pins. A simple register bus reaches three byte-wide registers: a value register, a direction register and a per-pin change-notify enable register. The block drives the pin output enables from the direction register. It passes every pin input through a two-flop synchroniser, and it watches the synchronised levels for transitions.

When an enabled input pin changes level, the block asks the host interface engine to send an unsolicited report. That report is a one-byte read response of the value register. The request is a level that holds until the engine acknowledges it. The byte offered alongside it is the value register as it reads at that moment. After each acknowledged report a hold-off window starts, with a length in clock cycles set by a parameter. The default is 4 ms at 100 MHz. Changes that occur while a report waits, or during the hold-off, merge into a single later report.

Top module: `gpio_notify`

## Requirements
- R1: After reset the direction, enable and output latch registers are all zero, pinOe is 0000 and sendReq is low.
- R2: Bus address 1 is the direction register. Bit i set to 1 makes pin i an output, so pinOe[i] equals that bit from the cycle after the write.
- R3: A write to address 0 updates output latch bit i only if pin i is an output at the time of the write. pinOut[i] is the latch bit AND the direction bit.
- R4: A read of address 0 returns, in bit i, the latch bit for an output pin and the synchronised input for an input pin. A pin level that is sampled at one clock edge becomes visible after the following edge.
- R5: Bits 7:4 of addresses 0, 1 and 2 read as zero and do not store written data. Address 3 reads as zero and ignores writes.
- R6: A transition of the synchronised level of a pin with enable bit 1 (address 2) and direction 0 raises sendReq on the clock edge after the transition becomes visible at address 0.
- R7: Transitions on pins whose enable bit is 0, or whose direction bit is 1, never raise sendReq.
- R8: sendReq stays high until a cycle with sendAck high. sendData always equals the current address 0 read value.
- R9: After an acknowledged report, sendReq stays low for HOLDOFF cycles. Any number of qualifying changes during that time produce exactly one request afterwards.
- R10: A qualifying change that arrives in the same cycle as an acknowledge is not lost. It produces a new request after the hold-off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Bus access in this cycle |
| busWr | input | 1 | Access is a write |
| busAddr | input | 2 | Register address |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for busAddr (combinational) |
| pinIn | input | 4 | Pin input levels (asynchronous) |
| pinOut | output | 4 | Pin output levels |
| pinOe | output | 4 | Pin output enables |
| sendReq | output | 1 | Request for an unsolicited report |
| sendData | output | 8 | Report byte (address 0 view) |
| sendAck | input | 1 | Host engine takes the report |

## Verification
The assertions assume that rstN is low when simulation starts. They also assume that sendAck is only meaningful while sendReq is high. A stray acknowledge with no request pending must not be counted as the start of a hold-off. The bench drives every input one time unit after the rising edge. It holds reset low for the first cycles and raises sendAck only in windows that the reference model treats the same way as the design. Pin inputs change freely, because the synchroniser absorbs them.

// File: rtl/gpio_notify_pkg.sv
package gpio_notify_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_VAL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_DIR = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_IEN = 2'd2;

  typedef struct packed {
    logic wrVal;
    logic wrDir;
    logic wrIen;
  } regStrobe_t;
endpackage

// File: rtl/gpio_notify_dp.sv
module gpio_notify_dp
  import gpio_notify_pkg::*;
#(
  parameter int PINS = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strobe,
  input  logic [PINS-1:0]   wdata,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [PINS-1:0]   pinIn,
  output logic [DATA_W-1:0] rdata,
  output logic [PINS-1:0]   pinOut,
  output logic [PINS-1:0]   pinOe,
  output logic [PINS-1:0]   pinView,
  output logic              changeHit
);
  logic [PINS-1:0] dirVec;
  logic [PINS-1:0] ienVec;
  logic [PINS-1:0] hitVec;

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    logic syncA, syncB, prevB;
    logic dirQ, ienQ, valQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncA <= 1'b0;
        syncB <= 1'b0;
        prevB <= 1'b0;
        dirQ  <= 1'b0;
        ienQ  <= 1'b0;
        valQ  <= 1'b0;
      end else begin
        syncA <= pinIn[i];
        syncB <= syncA;
        prevB <= syncB;
        if (strobe.wrDir) dirQ <= wdata[i];
        if (strobe.wrIen) ienQ <= wdata[i];
        if (strobe.wrVal && dirQ) valQ <= wdata[i];
      end
    end

    assign dirVec[i]  = dirQ;
    assign ienVec[i]  = ienQ;
    assign pinView[i] = dirQ ? valQ : syncB;
    assign pinOut[i]  = valQ & dirQ;
    assign hitVec[i]  = (syncB ^ prevB) & ienQ & ~dirQ;
  end

  assign pinOe     = dirVec;
  assign changeHit = |hitVec;

  always_comb begin
    rdata = '0;
    case (rdAddr)
      ADDR_VAL: rdata[PINS-1:0] = pinView;
      ADDR_DIR: rdata[PINS-1:0] = dirVec;
      ADDR_IEN: rdata[PINS-1:0] = ienVec;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_notify_ctrl.sv
module gpio_notify_ctrl
  import gpio_notify_pkg::*;
#(
  parameter int HOLDOFF = 400000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              changeHit,
  input  logic              sendAck,
  output regStrobe_t        strobe,
  output logic              sendReq
);
  localparam int CNT_W = $clog2(HOLDOFF + 1);
  localparam logic [CNT_W-1:0] HOLD_LOAD = CNT_W'(HOLDOFF);

  logic             pending;
  logic [CNT_W-1:0] holdCnt;
  logic             ackFire;

  always_comb begin
    strobe.wrVal = busSel && busWr && (busAddr == ADDR_VAL);
    strobe.wrDir = busSel && busWr && (busAddr == ADDR_DIR);
    strobe.wrIen = busSel && busWr && (busAddr == ADDR_IEN);
  end

  assign sendReq = pending && (holdCnt == '0);
  assign ackFire = sendReq && sendAck;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= 1'b0;
      holdCnt <= '0;
    end else begin
      pending <= changeHit || (pending && !ackFire);
      if (ackFire)
        holdCnt <= HOLD_LOAD;
      else if (holdCnt != '0)
        holdCnt <= holdCnt - 1'b1;
    end
  end
endmodule

// File: rtl/gpio_notify.sv
module gpio_notify
  import gpio_notify_pkg::*;
#(
  parameter int PINS = 4,
  parameter int DATA_W = 8,
  parameter int HOLDOFF = 400000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [1:0]        busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [PINS-1:0]   pinIn,
  output logic [PINS-1:0]   pinOut,
  output logic [PINS-1:0]   pinOe,
  output logic              sendReq,
  output logic [DATA_W-1:0] sendData,
  input  logic              sendAck
);
  regStrobe_t      strobe;
  logic            changeHit;
  logic [PINS-1:0] pinView;

  gpio_notify_ctrl #(.HOLDOFF(HOLDOFF)) u_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .changeHit(changeHit), .sendAck(sendAck),
    .strobe(strobe), .sendReq(sendReq)
  );

  gpio_notify_dp #(.PINS(PINS), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wdata(busWdata[PINS-1:0]),
    .rdAddr(busAddr), .pinIn(pinIn), .rdata(busRdata), .pinOut(pinOut),
    .pinOe(pinOe), .pinView(pinView), .changeHit(changeHit)
  );

  always_comb begin
    sendData = '0;
    sendData[PINS-1:0] = pinView;
  end
endmodule

// File: rtl/gpio_notify_chk.sv
module gpio_notify_chk #(
  parameter int PINS = 4,
  parameter int DATA_W = 8,
  parameter int HOLDOFF = 400000
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWr,
  input logic [1:0]        busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic [DATA_W-1:0] busRdata,
  input logic [PINS-1:0]   pinOe,
  input logic              sendReq,
  input logic              sendAck
);
  localparam int CNT_W = $clog2(HOLDOFF + 1);
  logic [CNT_W-1:0] sinceAck;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceAck <= CNT_W'(HOLDOFF);
    else if (sendReq && sendAck) sinceAck <= '0;
    else if (sinceAck < CNT_W'(HOLDOFF)) sinceAck <= sinceAck + 1'b1;
  end

  // R1
  p_reset_quiet_r1: assert property (@(posedge clk)
    $rose(rstN) |-> (!sendReq && pinOe == '0));

  // R2
  p_dir_drives_oe_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWr && busAddr == 2'd1) |=> (pinOe == $past(busWdata[PINS-1:0])));

  // R5
  p_upper_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    busRdata[DATA_W-1:PINS] == '0);

  // R8
  p_req_held_r8: assert property (@(posedge clk) disable iff (!rstN)
    (sendReq && !sendAck) |=> sendReq);

  // R9
  p_holdoff_r9: assert property (@(posedge clk) disable iff (!rstN)
    sendReq |-> (sinceAck == CNT_W'(HOLDOFF)));
endmodule

bind gpio_notify gpio_notify_chk #(.PINS(PINS), .DATA_W(DATA_W), .HOLDOFF(HOLDOFF)) u_chk (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
  .busWdata(busWdata), .busRdata(busRdata), .pinOe(pinOe),
  .sendReq(sendReq), .sendAck(sendAck)
);

// File: tb/tb_gpio_notify.sv
`timescale 1ns/1ps
module tb_gpio_notify;
  localparam int HOLD = 40;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busSel = 1'b0, busWr = 1'b0;
  logic [1:0] busAddr = 2'd0;
  logic [7:0] busWdata = 8'h00;
  logic [7:0] busRdata;
  logic [3:0] pinIn = 4'h0, pinOut, pinOe;
  logic       sendReq, sendAck = 1'b0;
  logic [7:0] sendData;

  gpio_notify #(.PINS(4), .DATA_W(8), .HOLDOFF(HOLD)) dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .pinIn(pinIn), .pinOut(pinOut),
    .pinOe(pinOe), .sendReq(sendReq), .sendData(sendData), .sendAck(sendAck)
  );

  always #5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  string tag = "R1";
  bit done = 0;

  // Behavioural reference state
  bit [3:0] mS1 = 0, mS2 = 0, mPrev = 0, mDir = 0, mIen = 0, mVal = 0;
  bit       mPend = 0;
  int       mCnt = 0;

  function automatic bit [3:0] viewOf();
    bit [3:0] v;
    for (int i = 0; i < 4; i++) v[i] = mDir[i] ? mVal[i] : mS2[i];
    return v;
  endfunction

  always @(posedge clk) begin
    bit [3:0] chg;
    bit ack;
    cyc++;
    if (!rstN) begin
      mS1 = 0; mS2 = 0; mPrev = 0; mDir = 0; mIen = 0; mVal = 0; mPend = 0; mCnt = 0;
    end else begin
      chg = (mS2 ^ mPrev) & mIen & ~mDir;
      ack = mPend && (mCnt == 0) && sendAck;
      if (busSel && busWr) begin
        case (busAddr)
          2'd0: for (int i = 0; i < 4; i++) if (mDir[i]) mVal[i] = busWdata[i];
          2'd1: mDir = busWdata[3:0];
          2'd2: mIen = busWdata[3:0];
          default: ;
        endcase
      end
      mPend = (chg != 0) || (mPend && !ack);
      if (ack) mCnt = HOLD;
      else if (mCnt > 0) mCnt--;
      mPrev = mS2; mS2 = mS1; mS1 = pinIn;
    end
  end

  task automatic cmp(string name, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h (cycle %0d)", tag, name, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      bit [7:0] rd;
      case (busAddr)
        2'd0: rd = {4'h0, viewOf()};
        2'd1: rd = {4'h0, mDir};
        2'd2: rd = {4'h0, mIen};
        default: rd = 8'h00;
      endcase
      cmp("pinOe", {4'h0, pinOe}, {4'h0, mDir});
      cmp("pinOut", {4'h0, pinOut}, {4'h0, mVal & mDir});
      cmp("busRdata", busRdata, rd);
      cmp("sendReq", {7'h0, sendReq}, {7'h0, (mPend && mCnt == 0)});
      cmp("sendData", sendData, {4'h0, viewOf()});
    end
  end

  task automatic step(int n);
    repeat (n) begin
      @(posedge clk); #1;
      if (!(busSel && busWr)) busAddr = busAddr + 2'd1;
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(posedge clk); #1;
    busSel = 1; busWr = 1; busAddr = a; busWdata = d;
    @(posedge clk); #1;
    busSel = 0; busWr = 0;
  endtask

  initial begin
    tag = "R1"; step(3); rstN = 1; step(3);
    tag = "R2/R5"; wr(2'd1, 8'hF5); step(3); wr(2'd3, 8'hFF); step(4); wr(2'd2, 8'hF0); step(4);
    tag = "R3"; wr(2'd0, 8'hFF); step(2); wr(2'd1, 8'h0F); step(3); wr(2'd0, 8'h0A); step(3);
    tag = "R4"; wr(2'd1, 8'h03); pinIn = 4'b1100; step(4); pinIn = 4'b0110; step(4);
    tag = "R7"; wr(2'd2, 8'h00); pinIn = 4'b1001; step(4); pinIn = 4'b0000; step(4);
    wr(2'd2, 8'h03); pinIn = 4'b0011; step(4); pinIn = 4'b0000; step(4);
    tag = "R6/R8"; wr(2'd1, 8'h00); wr(2'd2, 8'h05); step(5);
    pinIn[0] = 1; step(8); sendAck = 1; step(1); sendAck = 0;
    tag = "R9"; step(3); pinIn[2] = 1; step(3); pinIn[2] = 0; step(3); pinIn[0] = 0; step(HOLD + 8);
    sendAck = 1; step(2); sendAck = 0;
    tag = "R10"; step(HOLD + 4); pinIn[2] = 1; step(6);
    pinIn[0] = 1; step(2); sendAck = 1; step(1); sendAck = 0;
    step(HOLD + 8); sendAck = 1; step(2); sendAck = 0; step(HOLD + 4);
    tag = "R7"; pinIn[1] = 1; step(6);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(150000 * 10);
    done = 1;
    checks++; fails++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule